// File: doc/BRIEF.md
# Bus Ownership and Lock Controller

This block manages one agent's ownership of an external bus that several masters share. On its local side it takes single reads, single writes and indivisible read-modify-write requests through a valid/ready handshake. On the bus side it drives an active-low request line and reads a grant input. It also reads the shared active-low busy line and drives it back through its own drive-enable. An active-low lock output completes the bus side. Every bus output is registered, so it changes only on a rising clock edge. The drive-enables let the bench model open pads with a pull-up.

Once the agent owns the bus it keeps the bus parked and keeps busy asserted. Further local requests are then served with no new arbitration, until the grant is taken away. The agent then finishes any transfer in progress, including both halves of a locked cycle. After that it drives busy high for one cycle and lets the line float. A locked cycle consists of one read cycle, `GAP_CYCLES` idle cycles and one write cycle, and lock stays low for all of them. A software hold input can also force lock low.

Top module: `busOwnerLock`

## Requirements
- R1: `brN` is low only while the block is arbitrating for a pending request without owning the bus, and never while `busyOe` is high.
- R2: The block claims the bus only after a clock edge at which `busGrant` is high and `busyIn` is sampled high. From the next cycle it drives busy low (`busyOe`=1, `busyOut`=0). While `busyIn` is low it keeps waiting.
- R3: After a transfer the owner stays parked, with busy driven low and `brN` high. A new request is accepted at the next edge with no arbitration cycles.
- R4: When the grant is low in a parked cycle, the next cycle drives busy high (`busyOe`=1, `busyOut`=1). The cycle after that turns `busyOe` off.
- R5: A locked cycle (`reqKind`=2) holds `lockN` low for one read cycle, then `GAP_CYCLES` idle cycles, then one write cycle. `lockN` goes high in the cycle after the write.
- R6: Outside a locked cycle `lockN` stays high. This covers single transfers, parked cycles and idle cycles.
- R7: `lockHold` forces `lockN` low from the cycle after it is sampled high until the cycle after it is sampled low.
- R8: During reset `brN`=1, `lockN`=1, `lockOe`=1, `busyOe`=0 and `busPhase`=0. `lockOe` is 1 at all times.
- R9: If the grant is removed during a locked cycle, the read, the gap and the write still complete, followed by one parked cycle and then the R4 release.
- R10: `reqReady` is high only while the block owns the bus and `busGrant` is high. Each phase lasts one cycle. `busPhase` is 1 for a read, 2 for a write and 0 otherwise. `reqKind` 0 is a read, 1 is a write, 2 is a locked cycle, and 3 is handled as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Local request valid |
| reqKind | input | 2 | 0 read, 1 write, 2 locked read-modify-write, 3 read |
| reqReady | output | 1 | Request accepted at this edge |
| lockHold | input | 1 | Software control that forces lock low |
| busGrant | input | 1 | Grant from the arbiter |
| busyIn | input | 1 | Sampled shared busy line |
| brN | output | 1 | Active-low bus request |
| busyOut | output | 1 | Busy value driven onto the line |
| busyOe | output | 1 | Busy drive-enable |
| lockN | output | 1 | Active-low bus lock |
| lockOe | output | 1 | Lock drive-enable |
| busPhase | output | 2 | Current bus phase: 0 none, 1 read, 2 write |

## Verification
Two agents share one wired-AND busy line with a pull-up default. Ownership is first handed from one agent to the other while the first one still holds busy low. This shows that the grant alone does not let the second agent take the bus. All four request codes are then swept, each with the hold control off and on. This separates lock driven by a locked cycle from lock driven by the hold control, and shows that a plain transfer never asserts lock. Finally, the grant is removed at every cycle offset of a locked cycle. This shows whether the bus can ever be released between the read and the write.

// File: rtl/busOwnPkg.sv
package busOwnPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_PARK, S_XFER, S_RD, S_GAP, S_WR, S_REL
  } ownStateT;

  localparam logic [1:0] KIND_RD  = 2'd0;
  localparam logic [1:0] KIND_WR  = 2'd1;
  localparam logic [1:0] KIND_RMW = 2'd2;

  localparam logic [1:0] PH_NONE = 2'd0;
  localparam logic [1:0] PH_RD   = 2'd1;
  localparam logic [1:0] PH_WR   = 2'd2;

  typedef struct packed {
    logic       reqBus;
    logic       drvBusy;
    logic       busyHigh;
    logic       lockRmw;
    logic       gapLoad;
    logic [1:0] phase;
  } ownStrobeT;

endpackage

// File: rtl/busOwnCtrl.sv
module busOwnCtrl
  import busOwnPkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       busGrant,
  input  logic       busyIn,
  input  logic       gapDone,
  output logic       reqReady,
  output ownStrobeT  stb
);

  localparam bit HAS_GAP = (GAP_CYCLES > 0);

  ownStateT st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  assign reqReady = (st == S_PARK) && busGrant;

  always_comb begin
    stNext = st;
    unique case (st)
      S_IDLE: if (reqValid) stNext = S_ARB;
      S_ARB: begin
        if (!reqValid)              stNext = S_IDLE;
        else if (busGrant && busyIn) stNext = S_PARK;
      end
      S_PARK: begin
        if (!busGrant)     stNext = S_REL;
        else if (reqValid) stNext = (reqKind == KIND_RMW) ? S_RD : S_XFER;
      end
      S_XFER: stNext = S_PARK;
      S_RD:   stNext = HAS_GAP ? S_GAP : S_WR;
      S_GAP:  if (gapDone) stNext = S_WR;
      S_WR:   stNext = S_PARK;
      S_REL:  stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.reqBus   = (stNext == S_ARB);
    stb.drvBusy  = (stNext inside {S_PARK, S_XFER, S_RD, S_GAP, S_WR, S_REL});
    stb.busyHigh = (stNext == S_REL);
    stb.lockRmw  = (stNext inside {S_RD, S_GAP, S_WR});
    stb.gapLoad  = (stNext == S_GAP) && (st != S_GAP);
    if (stNext == S_XFER)
      stb.phase = (reqKind == KIND_WR) ? PH_WR : PH_RD;
    else if (stNext == S_RD)
      stb.phase = PH_RD;
    else if (stNext == S_WR)
      stb.phase = PH_WR;
    else
      stb.phase = PH_NONE;
  end

  // Once a locked read has started, only the gap or the write may follow.
  assert_locked_no_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st inside {S_RD, S_GAP}) |=> (st inside {S_GAP, S_WR}));

  // Parking ends only through the drive-high release cycle.
  assert_park_release_path_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PARK && !busGrant) |=> (st == S_REL));

endmodule

// File: rtl/busOwnDp.sv
module busOwnDp
  import busOwnPkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  ownStrobeT  stb,
  input  logic       lockHold,
  output logic       brN,
  output logic       busyOut,
  output logic       busyOe,
  output logic       lockN,
  output logic       lockOe,
  output logic [1:0] busPhase,
  output logic       gapDone
);

  localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brN      <= 1'b1;
      busyOut  <= 1'b1;
      busyOe   <= 1'b0;
      lockN    <= 1'b1;
      busPhase <= PH_NONE;
    end else begin
      brN      <= !stb.reqBus;
      busyOut  <= !stb.drvBusy || stb.busyHigh;
      busyOe   <= stb.drvBusy;
      lockN    <= !(stb.lockRmw || lockHold);
      busPhase <= stb.phase;
    end
  end

  assign lockOe = 1'b1;

  generate
    if (GAP_CYCLES == 0) begin : gNoGap
      assign gapDone = 1'b1;
    end else begin : gGap
      logic [CNT_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 gapCnt <= '0;
        else if (stb.gapLoad)      gapCnt <= CNT_W'(GAP_CYCLES - 1);
        else if (gapCnt != '0)     gapCnt <= gapCnt - 1'b1;
      end
      assign gapDone = (gapCnt == '0);
    end
  endgenerate

  // A release cycle that drives busy high is always followed by the line floating.
  assert_release_float_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busyOe && busyOut) |=> !busyOe);

  // A read with lock held is followed by a locked gap or a locked write.
  assert_lock_through_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busPhase == PH_RD && !lockN && !lockHold && !$past(lockHold)) |=> !lockN);

endmodule

// File: rtl/busOwnerLock.sv
module busOwnerLock
  import busOwnPkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output logic       reqReady,
  input  logic       lockHold,
  input  logic       busGrant,
  input  logic       busyIn,
  output logic       brN,
  output logic       busyOut,
  output logic       busyOe,
  output logic       lockN,
  output logic       lockOe,
  output logic [1:0] busPhase
);

  ownStrobeT stb;
  logic      gapDone;

  busOwnCtrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .busGrant(busGrant), .busyIn(busyIn), .gapDone(gapDone),
    .reqReady(reqReady), .stb(stb)
  );

  busOwnDp #(.GAP_CYCLES(GAP_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lockHold(lockHold),
    .brN(brN), .busyOut(busyOut), .busyOe(busyOe), .lockN(lockN),
    .lockOe(lockOe), .busPhase(busPhase), .gapDone(gapDone)
  );

  // Request is never asserted while this agent drives busy.
  assert_no_request_when_owner_R1: assert property (@(posedge clk) disable iff (!rstN)
    !brN |-> !busyOe);

  // Driving busy starts only after busy was seen high with a grant.
  assert_claim_after_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyOe && !busyOut && !$past(busyOe)) |-> ($past(busyIn) && $past(busGrant)));

  // Ready only while owning the bus.
  assert_ready_needs_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busyOe && !busyOut));

endmodule

// File: tb/busOwnerLock_bench.sv
module busOwnerLock_bench;

  localparam int G = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic validA, holdA, grantA, validB, grantB;
  logic [1:0] kindA;
  logic readyA, brA, outA, oeA, lockA, lockOeA;
  logic [1:0] phA;
  logic readyB, brB, outB, oeB, lockB, lockOeB;
  logic [1:0] phB;
  logic busyLine;

  int checks = 0;
  int errors = 0;

  assign busyLine = (oeA ? outA : 1'b1) & (oeB ? outB : 1'b1);

  busOwnerLock #(.GAP_CYCLES(G)) u_busOwnerLock (
    .clk(clk), .rstN(rstN), .reqValid(validA), .reqKind(kindA), .reqReady(readyA),
    .lockHold(holdA), .busGrant(grantA), .busyIn(busyLine), .brN(brA),
    .busyOut(outA), .busyOe(oeA), .lockN(lockA), .lockOe(lockOeA), .busPhase(phA)
  );

  busOwnerLock #(.GAP_CYCLES(G)) u_busOwnerLock_b (
    .clk(clk), .rstN(rstN), .reqValid(validB), .reqKind(2'd0), .reqReady(readyB),
    .lockHold(1'b0), .busGrant(grantB), .busyIn(busyLine), .brN(brB),
    .busyOut(outB), .busyOe(oeB), .lockN(lockB), .lockOe(lockOeB), .busPhase(phB)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Two agents must never both own the bus (R2).
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (oeA && !outA && oeB && !outB) begin
        errors++;
        $display("FAIL R2 dual owner: actual 2 expected 1");
      end
    end
  end

  task automatic acquireA();
    grantA = 1'b1; kindA = 2'd0; validA = 1'b1;
    tick(); tick();
    validA = 1'b0;
    chk("R2 reacquire own", int'(oeA && !outA), 1);
  endtask

  task automatic runXfer(input int k, input int hold);
    holdA = hold[0]; kindA = k[1:0]; validA = 1'b1;
    chk("R3 ready while parked", int'(readyA), 1);
    tick();
    validA = 1'b0;
    if (k == 2) begin
      for (int p = 0; p <= G + 1; p++) begin
        chk("R5 locked phase", int'(phA), (p == 0) ? 1 : ((p == G + 1) ? 2 : 0));
        chk("R5 lock low", int'(lockA), 0);
        chk("R3 owner during rmw", int'(oeA && !outA), 1);
        tick();
      end
    end else begin
      chk("R10 single phase", int'(phA), (k == 1) ? 2 : 1);
      chk("R6 R7 lock single", int'(lockA), hold ? 0 : 1);
      tick();
    end
    chk("R10 phase idle", int'(phA), 0);
    chk("R6 R7 lock after", int'(lockA), hold ? 0 : 1);
    chk("R3 parked", int'(oeA && !outA && brA), 1);
    holdA = 1'b0;
    tick();
    chk("R7 hold released", int'(lockA), 1);
  endtask

  initial begin
    rstN = 1'b0; validA = 0; holdA = 0; grantA = 0; validB = 0; grantB = 0; kindA = 0;
    repeat (3) @(negedge clk);
    chk("R8 brN", int'(brA), 1);
    chk("R8 lockN", int'(lockA), 1);
    chk("R8 lockOe", int'(lockOeA), 1);
    chk("R8 busyOe", int'(oeA), 0);
    chk("R8 phase", int'(phA), 0);
    rstN = 1'b1;

    // Agent B takes the bus.
    grantB = 1'b1; validB = 1'b1;
    tick();
    chk("R1 B request", int'(brB), 0);
    tick();
    chk("R2 B owns", int'(oeB && !outB), 1);
    validB = 1'b0;

    // Agent A is granted but must wait for busy to go high.
    validA = 1'b1; kindA = 2'd0; grantA = 1'b1;
    tick();
    chk("R1 A request", int'(brA), 0);
    tick();
    chk("R2 A waits on busy", int'(oeA), 0);
    chk("R1 A still requesting", int'(brA), 0);
    chk("R10 not ready", int'(readyA), 0);
    grantB = 1'b0;
    tick();
    chk("R4 B drives high", int'(oeB && outB), 1);
    chk("R2 A still waiting", int'(oeA), 0);
    tick();
    chk("R4 B floats", int'(oeB), 0);
    chk("R2 A owns", int'(oeA && !outA), 1);
    chk("R1 A request dropped", int'(brA), 1);
    chk("R10 A ready", int'(readyA), 1);
    validA = 1'b0;
    tick();
    chk("R3 parked no request", int'(oeA && !outA && brA), 1);
    chk("R6 idle lock high", int'(lockA), 1);

    for (int hold = 0; hold < 2; hold++)
      for (int k = 0; k < 4; k++)
        runXfer(k, hold);

    // Grant removal at every offset of a locked cycle.
    for (int d = 0; d <= G + 2; d++) begin
      kindA = 2'd2; validA = 1'b1;
      tick();
      validA = 1'b0;
      for (int p = 0; p <= G + 4; p++) begin
        chk("R9 busyOe", int'(oeA), (p <= G + 3) ? 1 : 0);
        if (p <= G + 3) chk("R9 R4 busy level", int'(outA), (p == G + 3) ? 1 : 0);
        chk("R9 lock", int'(lockA), (p <= G + 1) ? 0 : 1);
        chk("R9 phase", int'(phA), (p == 0) ? 1 : ((p == G + 1) ? 2 : 0));
        if (p >= G + 3) chk("R10 no ready", int'(readyA), 0);
        if (p == d) grantA = 1'b0;
        tick();
      end
      acquireA();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule